// File: doc/BRIEF.md
# Pipeline Hazard Control for a Five-Stage Integer Core

This block sits beside the pipeline registers of a five-stage integer core (fetch, decode, execute, memory, writeback). It steers both execute-stage operands to the freshest copy of a register value: the register-file read, the result waiting in the execute/memory register, or the result waiting in the memory/writeback register. When the same destination is pending in both, the younger one wins. For a dependence that bypassing cannot cover, it raises the control signals for the program counter and the two front pipeline registers.

That case is a load in execute whose destination a decode-stage instruction reads. The program counter and the fetch/decode register keep their contents for one cycle, and a bubble enters the decode/execute register. When execute resolves a control transfer (a jump, a taken branch or a trap redirect), the two younger instructions are discarded by clearing the fetch/decode and decode/execute registers. All outputs are combinational in the current cycle's inputs. The clock and reset inputs serve only the embedded checks.

Top module: `hazard_ctrl`

## Requirements
- R1: An execute operand select is 1 (execute/memory result) when the execute/memory write enable is set, its destination is nonzero and equal to that operand's source index.
- R2: When the execute/memory and memory/writeback stages both write a nonzero destination equal to the source, the select is 1, never 2.
- R3: An operand select is 2 (memory/writeback result) when only the memory/writeback stage writes a nonzero destination equal to the source.
- R4: In every other case the select is 0 (register-file value), and a source index of 0 always gives 0; the value 3 never appears.
- R5: A load-use hazard stalls the front end. The execute instruction must be a load with a nonzero destination equal to either decode source, and no redirect may be active. In that case the PC hold and fetch/decode hold are 1, the decode/execute clear is 1 (bubble), and the fetch/decode clear is 0.
- R6: No stall or bubble arises when the execute instruction is not a load, when the load's destination is 0, or when neither decode source matches it.
- R7: A redirect from execute sets both the fetch/decode clear and the decode/execute clear.
- R8: When a redirect and a load-use hazard coincide, the redirect wins: both holds are 0 and both clears are 1.
- R9: A stage whose write enable is low is never chosen as a bypass source, even when its destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| id_rs1 | input | IDX_W | First source index of the decode-stage instruction |
| id_rs2 | input | IDX_W | Second source index of the decode-stage instruction |
| ex_rs1 | input | IDX_W | First source index of the execute-stage instruction |
| ex_rs2 | input | IDX_W | Second source index of the execute-stage instruction |
| ex_rd | input | IDX_W | Destination index of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction reads memory |
| exmem_rd | input | IDX_W | Destination held in the execute/memory register |
| exmem_we | input | 1 | Register write enable held in the execute/memory register |
| memwb_rd | input | IDX_W | Destination held in the memory/writeback register |
| memwb_we | input | 1 | Register write enable held in the memory/writeback register |
| ex_redirect | input | 1 | Jump, taken branch or trap redirect resolved in execute |
| fwd_a | output | 2 | Select for operand A: 0 register file, 1 execute/memory, 2 memory/writeback |
| fwd_b | output | 2 | Select for operand B, same encoding |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| ifid_clear | output | 1 | Clear the fetch/decode register |
| idex_clear | output | 1 | Clear the decode/execute register (bubble or squash) |

## Verification
Directed cases pin each bypass source alone: both stages on the same index to tell the priority apart, a disabled write on a matching index, and index 0 against an enabled write. They also cover a load with and without a matching decode source, a load to index 0, a redirect alone, and a redirect together with a load-use hazard, which separates stall-only from flush-wins behaviour. Random stimulus draws every index from a narrow range so that matches are frequent. That range mixes coincident producers, disabled writes and simultaneous stall and flush requests, and each result is compared with bench functions written from the requirements.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_EXMEM   = 2'd1,
    SRC_MEMWB   = 2'd2
  } byp_src_e;
endpackage

// File: rtl/hz_bypass_pick.sv
module hz_bypass_pick
  import hazard_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic [IDX_W-1:0] memwb_rd,
  input  logic             memwb_we,
  output byp_src_e         sel
);
  function automatic logic producer_hit(input logic we, input logic [IDX_W-1:0] rd,
                                        input logic [IDX_W-1:0] s);
    return we && (rd != '0) && (rd == s);
  endfunction

  logic hit_exmem, hit_memwb;
  assign hit_exmem = producer_hit(exmem_we, exmem_rd, src);
  assign hit_memwb = producer_hit(memwb_we, memwb_rd, src);

  always_comb begin
    if (hit_exmem)      sel = SRC_EXMEM;
    else if (hit_memwb) sel = SRC_MEMWB;
    else                sel = SRC_REGFILE;
  end

  AST_ZERO_SRC_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_REGFILE)); // R4
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'd3); // R4
  AST_NEWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_exmem && hit_memwb) |-> (sel == SRC_EXMEM)); // R2
  AST_DISABLED_NOT_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (!exmem_we && !memwb_we) |-> (sel == SRC_REGFILE)); // R9
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_is_load,
  output logic             need_stall
);
  logic dest_live, src_match;
  assign dest_live  = ex_is_load && (ex_rd != '0);
  assign src_match  = (ex_rd == id_rs1) || (ex_rd == id_rs2);
  assign need_stall = dest_live && src_match;

  AST_ZERO_DEST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !need_stall); // R6
  AST_NONLOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !need_stall); // R6
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic need_stall,
  input  logic redirect,
  output logic pc_hold,
  output logic ifid_hold,
  output logic ifid_clear,
  output logic idex_clear
);
  logic stall_eff;
  assign stall_eff  = need_stall && !redirect;
  assign pc_hold    = stall_eff;
  assign ifid_hold  = stall_eff;
  assign ifid_clear = redirect;
  assign idex_clear = redirect || stall_eff;

  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!pc_hold && !ifid_hold && ifid_clear && idex_clear)); // R8
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (need_stall && !redirect) |-> (pc_hold && ifid_hold && idex_clear && !ifid_clear)); // R5
  AST_HOLD_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |-> need_stall); // R6
  AST_CLEAR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_clear |-> idex_clear); // R7
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_is_load,
  input  logic [IDX_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic [IDX_W-1:0] memwb_rd,
  input  logic             memwb_we,
  input  logic             ex_redirect,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ifid_clear,
  output logic             idex_clear
);
  localparam int N_OPS = 2;

  logic [IDX_W-1:0] op_src [N_OPS];
  byp_src_e         op_sel [N_OPS];
  logic             load_hazard;

  assign op_src[0] = ex_rs1;
  assign op_src[1] = ex_rs2;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_bypass_pick #(.IDX_W(IDX_W)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (op_src[g]),
      .exmem_rd (exmem_rd),
      .exmem_we (exmem_we),
      .memwb_rd (memwb_rd),
      .memwb_we (memwb_we),
      .sel      (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hz_load_use #(.IDX_W(IDX_W)) u_load_use (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .ex_rd      (ex_rd),
    .ex_is_load (ex_is_load),
    .need_stall (load_hazard)
  );

  hz_pipe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .need_stall (load_hazard),
    .redirect   (ex_redirect),
    .pc_hold    (pc_hold),
    .ifid_hold  (ifid_hold),
    .ifid_clear (ifid_clear),
    .idex_clear (idex_clear)
  );

  AST_EXMEM_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_we && exmem_rd != '0 && exmem_rd == ex_rs1) |-> (fwd_a == 2'd1)); // R1
  AST_MEMWB_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!exmem_we && memwb_we && memwb_rd != '0 && memwb_rd == ex_rs2) |-> (fwd_b == 2'd2)); // R3
  AST_REDIRECT_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> (ifid_clear && idex_clear)); // R7
endmodule

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDX_W-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic [IDX_W-1:0] exmem_rd = '0, memwb_rd = '0;
  logic ex_is_load = 1'b0, exmem_we = 1'b0, memwb_we = 1'b0, ex_redirect = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ifid_clear, idex_clear;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hazard_ctrl #(.IDX_W(IDX_W)) u_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we),
    .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .ex_redirect(ex_redirect),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_clear(ifid_clear), .idex_clear(idex_clear)
  );

  // Expected bypass choice: newest enabled nonzero producer first.
  function automatic logic [1:0] want_sel(input logic [IDX_W-1:0] s);
    if (s == 0) return 2'd0;
    if (exmem_we && exmem_rd == s) return 2'd1;
    if (memwb_we && memwb_rd == s) return 2'd2;
    return 2'd0;
  endfunction

  // Expected {pc_hold, ifid_hold, ifid_clear, idex_clear}.
  function automatic logic [3:0] want_ctrl();
    logic hz;
    hz = ex_is_load && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    if (ex_redirect) return 4'b0011;
    if (hz) return 4'b1101;
    return 4'b0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [IDX_W-1:0] a1, a2, b1, b2, rd, input logic ld,
                       input logic [IDX_W-1:0] xr, input logic xw,
                       input logic [IDX_W-1:0] wr, input logic ww, input logic rdir);
    @(negedge clk);
    id_rs1 = a1; id_rs2 = a2; ex_rs1 = b1; ex_rs2 = b2; ex_rd = rd; ex_is_load = ld;
    exmem_rd = xr; exmem_we = xw; memwb_rd = wr; memwb_we = ww; ex_redirect = rdir;
    #1;
  endtask

  function automatic logic [3:0] got_ctrl();
    return {pc_hold, ifid_hold, ifid_clear, idex_clear};
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset fwd_a", fwd_a, 0);
    chk("R4 reset fwd_b", fwd_b, 0);
    chk("R6 reset ctrl", got_ctrl(), 0);
    rst_n = 1'b1;

    drive(0, 0, 5, 6, 0, 0, 5, 1, 0, 0, 0);
    chk("R1 exmem bypass a", fwd_a, 1);
    chk("R4 no match b", fwd_b, 0);

    drive(0, 0, 5, 5, 0, 0, 5, 1, 5, 1, 0);
    chk("R2 newest wins a", fwd_a, 1);
    chk("R2 newest wins b", fwd_b, 1);

    drive(0, 0, 4, 7, 0, 0, 3, 1, 7, 1, 0);
    chk("R3 memwb only b", fwd_b, 2);
    chk("R4 unmatched a", fwd_a, 0);

    drive(0, 0, 5, 5, 0, 0, 5, 0, 5, 1, 0);
    chk("R9 disabled exmem skipped", fwd_a, 2);
    drive(0, 0, 5, 5, 0, 0, 9, 1, 5, 0, 0);
    chk("R9 disabled memwb skipped", fwd_b, 0);

    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    chk("R4 x0 never bypassed a", fwd_a, 0);
    chk("R4 x0 never bypassed b", fwd_b, 0);

    drive(1, 3, 0, 0, 3, 1, 0, 0, 0, 0, 0);
    chk("R5 load-use stall", got_ctrl(), 4'b1101);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 load to x0 no stall", got_ctrl(), 0);
    drive(3, 3, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    chk("R6 non-load no stall", got_ctrl(), 0);
    drive(1, 2, 0, 0, 3, 1, 0, 0, 0, 0, 0);
    chk("R6 load no match", got_ctrl(), 0);

    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 redirect squash", got_ctrl(), 4'b0011);
    drive(3, 0, 0, 0, 3, 1, 0, 0, 0, 0, 1);
    chk("R8 flush over stall", got_ctrl(), 4'b0011);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      drive($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
            1'($urandom), $urandom % 4, 1'($urandom), $urandom % 4, 1'($urandom),
            ($urandom % 5) == 0);
      chk("R1/R2/R3/R4/R9 random a", fwd_a, want_sel(ex_rs1));
      chk("R1/R2/R3/R4/R9 random b", fwd_b, want_sel(ex_rs2));
      chk("R5/R6/R7/R8 random ctrl", got_ctrl(), want_ctrl());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule